// File: doc/BRIEF.md
# Byte-Command SPI Master

This block is an SPI master that software drives one byte at a time through a small register file with eight-bit registers. Each byte is launched by writing a start command for one of two chip selects. A direction bit, latched at the start, makes the byte either a write cycle, which shifts the data register out on MOSI, or a read cycle, which shifts a byte in from MISO into the data register. The chosen chip select goes low at the start and stays low across later bytes. It is released only when software writes an end command, which also raises a transfer-end flag.

SCK is derived from one of two source clocks. Each source is presented as an edge-tick input that pulses once per edge of that source, at twice its frequency. The fast source divides by 2, 4, 6, 8, 10, 12, 14 or 1 for divisor index 0 to 7. The slow source divides by 2, 4, ... 16. Divide-by-one produces SCK at the source rate. Polarity and phase select among the four usual SPI modes. Bits are sent most significant first. A byte-done flag and the transfer-end flag, gated by an enable, form a registered interrupt line that software sees as a rising edge.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, both chip selects read 1, SCK and irq read 0, and every register at offsets 0 to 5 reads 0x00.
- R2: The register file is as follows. Offset 1 holds polarity in bit 6, phase in bit 5, the divisor index in bits 4:2 and the interrupt enable in bit 1. Offset 2 holds the read-cycle select in bit 2 and a stored, inactive blocking bit in bit 1. Offset 5 bit 6 selects the fast source. Unused bits read 0.
- R3: One SCK period lasts D source periods, which is 2*D ticks of the selected edge input. D is {2,4,6,8,10,12,14,1} for index 0 to 7 with the fast source, and {2,4,...,16} with the slow source.
- R4: A write cycle sends offset-0 data MSB first in all four polarity/phase modes. With phase 0 the data is valid before the leading edge and is sampled on it. With phase 1 the data changes on the leading edge and is sampled on the trailing edge.
- R5: A read cycle captures eight MISO bits MSB first into the data register at offset 0 and holds MOSI low throughout.
- R6: During a write cycle MISO is ignored, and the data register keeps the written byte.
- R7: Writing offset 3 with bit 4 set starts a byte on chip select 0. Bit 3 starts a byte on chip select 1. Bit 4 wins if both are set. At most one chip select is low, and it stays low after the byte.
- R8: A byte lasts 16 SCK half periods, counted from the clock edge that accepts the start. Byte-done (offset 4 bit 4) sets at the end of the 16th half period and is write-1-to-clear. A set and a clear in the same cycle leave it set.
- R9: Writing offset 3 with bit 5 set while no byte is shifting releases the chip select and sets transfer-end (offset 3 bit 1). Transfer-end is write-1-to-clear. End wins over a start in the same write, and no byte starts.
- R10: Offset 3 bit 2 reads 1 only while a byte is shifting. Bit 0 reads 1 while a chip select is low or a chip-select change is pending.
- R11: Start and end commands written while a byte is shifting or a chip-select change is pending are ignored.
- R12: A start on the other chip select while one is held first releases both chip selects for exactly one SCK period, then asserts the new one.
- R13: irq is a register that equals enable AND (byte-done OR transfer-end) one cycle later, so it stays 0 while the enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| fastEdge | input | 1 | Tick on every edge of the fast source clock |
| sysEdge | input | 1 | Tick on every edge of the slow source clock |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register offset |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational on regAddr) |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | 2 | Active-low chip selects |
| irq | output | 1 | Interrupt request |

## Verification
Two events can fall in the same core-clock cycle: the hardware setting byte-done at the end of a byte, and software's write-1-to-clear of that same flag. The bench runs a byte with the fast source at divide-by-one and the edge tick held high, so the byte ends exactly 16 cycles after the accepting edge. It places the clear write on that 16th edge. The flag must read 0 just before that edge and 1 just after it, and irq must follow one cycle later. A second collision is an end command and a start command carried in the same write. The bench judges it by the chip selects, the transfer-end flag, and the absence of a new byte.

// File: rtl/spi_bm_pkg.sv
`timescale 1ns/1ps
package spi_bm_pkg;
  localparam int BYTE_W    = 8;
  localparam int CS_N      = 2;
  localparam int DIV_IDX_W = 3;
  localparam int DIV_CNT_W = 5;
  localparam int ADDR_W    = 3;
  localparam int HALF_N    = 2 * BYTE_W;
  localparam int HALF_W    = $clog2(HALF_N);

  // register offsets (software-visible map)
  localparam logic [ADDR_W-1:0] A_DATA  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL1 = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL2 = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL3 = 3'd4;
  localparam logic [ADDR_W-1:0] A_CLKS  = 3'd5;

  // field positions
  localparam int B_POL    = 6;
  localparam int B_PHA    = 5;
  localparam int B_IDX_LO = 2;
  localparam int B_IEN    = 1;
  localparam int B_RDSEL  = 2;
  localparam int B_BLOCK  = 1;
  localparam int B_END    = 5;
  localparam int B_START0 = 4;
  localparam int B_START1 = 3;
  localparam int B_INPROG = 2;
  localparam int B_XEND   = 1;
  localparam int B_BUSY   = 0;
  localparam int B_BDONE  = 4;
  localparam int B_FAST   = 6;

  typedef enum logic [1:0] {ST_IDLE, ST_GAP, ST_SHIFT, ST_HOLD} seqState_t;

  typedef struct packed {
    logic              dataWe;
    logic [BYTE_W-1:0] wdata;
    logic              loadTx;
    logic              shiftTx;
    logic              sampleRx;
    logic              commitRx;
    logic              readCyc;
  } dpStrobe_t;

  // half-period length in source-edge ticks for a divisor index
  function automatic logic [DIV_CNT_W-1:0] halfTicks(input logic fast,
                                                     input logic [DIV_IDX_W-1:0] idx);
    if (idx == '1) return fast ? DIV_CNT_W'(1) : DIV_CNT_W'(2 ** DIV_IDX_W * 2);
    return DIV_CNT_W'(({2'b00, idx} + DIV_CNT_W'(1)) << 1);
  endfunction
endpackage

// File: rtl/spi_bm_clkdiv.sv
`timescale 1ns/1ps
module spi_bm_clkdiv
  import spi_bm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 run,
  input  logic                 fastSel,
  input  logic [DIV_IDX_W-1:0] divIdx,
  input  logic                 fastEdge,
  input  logic                 sysEdge,
  output logic                 halfEvt
);
  logic [DIV_CNT_W-1:0] cnt;
  logic [DIV_CNT_W-1:0] lim;
  logic tick;
  logic atLim;

  assign lim   = halfTicks(fastSel, divIdx) - DIV_CNT_W'(1);
  assign tick  = fastSel ? fastEdge : sysEdge;
  assign atLim = (cnt == lim);

  always_ff @(posedge clk) begin
    if (!rstN)      cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (tick)  cnt <= atLim ? '0 : cnt + DIV_CNT_W'(1);
  end

  assign halfEvt = run & tick & atLim;
endmodule

// File: rtl/spi_bm_datapath.sv
`timescale 1ns/1ps
module spi_bm_datapath
  import spi_bm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         dpStb,
  input  logic              miso,
  output logic              mosi,
  output logic [BYTE_W-1:0] dataQ
);
  logic [BYTE_W-1:0] txSh;
  logic [BYTE_W-1:0] rxSh;
  logic [BYTE_W-1:0] rxNext;

  always_comb rxNext = dpStb.sampleRx ? {rxSh[BYTE_W-2:0], miso} : rxSh;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txSh  <= '0;
      rxSh  <= '0;
      dataQ <= '0;
    end else begin
      if (dpStb.loadTx)       txSh <= dataQ;
      else if (dpStb.shiftTx) txSh <= {txSh[BYTE_W-2:0], 1'b0};
      rxSh <= rxNext;
      if (dpStb.commitRx)     dataQ <= rxNext;
      else if (dpStb.dataWe)  dataQ <= dpStb.wdata;
    end
  end

  assign mosi = dpStb.readCyc ? 1'b0 : txSh[BYTE_W-1];
endmodule

// File: rtl/spi_bm_ctrl.sv
`timescale 1ns/1ps
module spi_bm_ctrl
  import spi_bm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              fastEdge,
  input  logic              sysEdge,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWdata,
  output logic [BYTE_W-1:0] regRdata,
  input  logic [BYTE_W-1:0] dataQ,
  output dpStrobe_t         dpStb,
  output logic              sck,
  output logic [CS_N-1:0]   csN,
  output logic              irq
);
  logic cpol, cpha, ien, readSel, blockSel, fastSel;
  logic [DIV_IDX_W-1:0] divIdx;
  logic byteDone, xferEnd, irqQ, sckQ, byteRead;
  logic activeCh;
  seqState_t state;
  logic [HALF_W-1:0] halfIdx;

  logic wrCtl1, wrCtl2, wrClks, wrStat, wrCtl3;
  logic startReq, endReq, startCh, idleLike, acceptStart, acceptEnd;
  logic shifting, run, halfEvt, lead, lastHalf, byteEnd;

  assign wrCtl1 = regWe && (regAddr == A_CTRL1);
  assign wrCtl2 = regWe && (regAddr == A_CTRL2);
  assign wrClks = regWe && (regAddr == A_CLKS);
  assign wrStat = regWe && (regAddr == A_STAT);
  assign wrCtl3 = regWe && (regAddr == A_CTRL3);

  assign startReq = wrStat && (regWdata[B_START0] || regWdata[B_START1]);
  assign endReq   = wrStat && regWdata[B_END];
  assign startCh  = regWdata[B_START0] ? 1'b0 : 1'b1;

  assign idleLike    = (state == ST_IDLE) || (state == ST_HOLD);
  assign acceptEnd   = idleLike && endReq;
  assign acceptStart = idleLike && startReq && !endReq;

  assign shifting = (state == ST_SHIFT);
  assign run      = shifting || (state == ST_GAP);
  assign lead     = ~halfIdx[0];
  assign lastHalf = (halfIdx == HALF_W'(HALF_N - 1));
  assign byteEnd  = shifting && halfEvt && lastHalf;

  spi_bm_clkdiv uDiv (
    .clk      (clk),
    .rstN     (rstN),
    .run      (run),
    .fastSel  (fastSel),
    .divIdx   (divIdx),
    .fastEdge (fastEdge),
    .sysEdge  (sysEdge),
    .halfEvt  (halfEvt)
  );

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpol <= 1'b0; cpha <= 1'b0; ien <= 1'b0; divIdx <= '0;
      readSel <= 1'b0; blockSel <= 1'b0; fastSel <= 1'b0;
    end else begin
      if (wrCtl1) begin
        cpol   <= regWdata[B_POL];
        cpha   <= regWdata[B_PHA];
        divIdx <= regWdata[B_IDX_LO +: DIV_IDX_W];
        ien    <= regWdata[B_IEN];
      end
      if (wrCtl2) begin
        readSel  <= regWdata[B_RDSEL];
        blockSel <= regWdata[B_BLOCK];
      end
      if (wrClks) fastSel <= regWdata[B_FAST];
    end
  end

  // sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      activeCh <= 1'b0;
      byteRead <= 1'b0;
      halfIdx  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (acceptStart) begin
          activeCh <= startCh;
          byteRead <= readSel;
          halfIdx  <= '0;
          state    <= ST_SHIFT;
        end
        ST_HOLD: begin
          if (acceptEnd) state <= ST_IDLE;
          else if (acceptStart) begin
            byteRead <= readSel;
            halfIdx  <= '0;
            if (startCh == activeCh) state <= ST_SHIFT;
            else begin
              activeCh <= startCh;
              state    <= ST_GAP;
            end
          end
        end
        ST_GAP: if (halfEvt) begin
          if (halfIdx == HALF_W'(1)) begin
            halfIdx <= '0;
            state   <= ST_SHIFT;
          end else halfIdx <= halfIdx + HALF_W'(1);
        end
        ST_SHIFT: if (halfEvt) begin
          halfIdx <= halfIdx + HALF_W'(1);
          if (lastHalf) state <= ST_HOLD;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // serial clock, flags, interrupt
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sckQ     <= 1'b0;
      byteDone <= 1'b0;
      xferEnd  <= 1'b0;
      irqQ     <= 1'b0;
    end else begin
      if (!shifting)    sckQ <= cpol;
      else if (halfEvt) sckQ <= ~sckQ;
      byteDone <= byteEnd   | (byteDone & ~(wrCtl3 && regWdata[B_BDONE]));
      xferEnd  <= acceptEnd | (xferEnd  & ~(wrStat && regWdata[B_XEND]));
      irqQ     <= ien & (byteDone | xferEnd);
    end
  end

  assign sck = sckQ;
  assign irq = irqQ;

  // chip-select decode
  for (genvar c = 0; c < CS_N; c++) begin : g_cs
    assign csN[c] = !(((state == ST_SHIFT) || (state == ST_HOLD)) && (activeCh == c[0]));
  end

  // strobes toward the datapath
  always_comb begin
    dpStb          = '0;
    dpStb.dataWe   = regWe && (regAddr == A_DATA);
    dpStb.wdata    = regWdata;
    dpStb.loadTx   = acceptStart;
    dpStb.shiftTx  = shifting && halfEvt &&
                     (cpha ? (lead && (halfIdx != '0)) : !lead);
    dpStb.sampleRx = shifting && halfEvt && byteRead && (cpha ? !lead : lead);
    dpStb.commitRx = byteEnd && byteRead;
    dpStb.readCyc  = byteRead;
  end

  // register readback
  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      A_DATA:  regRdata = dataQ;
      A_CTRL1: begin
        regRdata[B_POL] = cpol;
        regRdata[B_PHA] = cpha;
        regRdata[B_IDX_LO +: DIV_IDX_W] = divIdx;
        regRdata[B_IEN] = ien;
      end
      A_CTRL2: begin
        regRdata[B_RDSEL] = readSel;
        regRdata[B_BLOCK] = blockSel;
      end
      A_STAT: begin
        regRdata[B_INPROG] = shifting;
        regRdata[B_XEND]   = xferEnd;
        regRdata[B_BUSY]   = (state != ST_IDLE);
      end
      A_CTRL3: regRdata[B_BDONE] = byteDone;
      A_CLKS:  regRdata[B_FAST]  = fastSel;
      default: regRdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_byte_master.sv
`timescale 1ns/1ps
module spi_byte_master
  import spi_bm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       fastEdge,
  input  logic       sysEdge,
  input  logic       regWe,
  input  logic [2:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  output logic       sck,
  output logic       mosi,
  input  logic       miso,
  output logic [1:0] csN,
  output logic       irq
);
  dpStrobe_t         dpStb;
  logic [BYTE_W-1:0] dataQ;

  spi_bm_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .fastEdge (fastEdge),
    .sysEdge  (sysEdge),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .dataQ    (dataQ),
    .dpStb    (dpStb),
    .sck      (sck),
    .csN      (csN),
    .irq      (irq)
  );

  spi_bm_datapath uDp (
    .clk   (clk),
    .rstN  (rstN),
    .dpStb (dpStb),
    .miso  (miso),
    .mosi  (mosi),
    .dataQ (dataQ)
  );
endmodule

// File: rtl/spi_bm_checker.sv
`timescale 1ns/1ps
module spi_bm_checker
  import spi_bm_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            mosi,
  input logic [CS_N-1:0] csN,
  input dpStrobe_t       dpStb
);
  p_single_cs_r7: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~csN) <= 1);

  p_no_direct_switch_r12: assert property (@(posedge clk) disable iff (!rstN)
    (($past(csN) != '1) && (csN != '1)) |-> (csN == $past(csN)));

  p_read_mosi_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    (dpStb.readCyc && (csN != '1)) |-> !mosi);

  p_strobes_in_frame_r8: assert property (@(posedge clk) disable iff (!rstN)
    (dpStb.shiftTx || dpStb.sampleRx || dpStb.commitRx) |-> (csN != '1));

  p_no_load_mid_byte_r11: assert property (@(posedge clk) disable iff (!rstN)
    dpStb.loadTx |-> !(dpStb.shiftTx || dpStb.sampleRx));
endmodule

bind spi_byte_master spi_bm_checker uChk (
  .clk   (clk),
  .rstN  (rstN),
  .mosi  (mosi),
  .csN   (csN),
  .dpStb (dpStb)
);

// File: tb/tb_spi_byte_master.sv
`timescale 1ns/1ps
module tb_spi_byte_master;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fastEdge = 1'b1;
  logic sysEdge = 1'b0;
  logic regWe = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic sck, mosi;
  logic miso = 1'b0;
  logic [1:0] csN;
  logic irq;

  int checks = 0;
  int errors = 0;
  int sysCnt = 0;
  logic tbCpol = 1'b0, tbCpha = 1'b0, prevSck = 1'b0;
  logic [7:0] sOut = '0, slvRx = '0;

  always #2 clk = ~clk;

  spi_byte_master dut (
    .clk(clk), .rstN(rstN), .fastEdge(fastEdge), .sysEdge(sysEdge),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .sck(sck), .mosi(mosi), .miso(miso), .csN(csN), .irq(irq)
  );

  // slow source: one edge tick every 3 core cycles
  always @(negedge clk) begin
    sysCnt  = (sysCnt == 2) ? 0 : sysCnt + 1;
    sysEdge = (sysCnt == 0);
  end

  // behavioural slave
  always @(negedge clk) begin
    if ((sck !== prevSck) && (csN != 2'b11)) begin
      if ((sck == 1'b1) == (tbCpol == tbCpha)) slvRx = {slvRx[6:0], mosi};
      else if (tbCpha) begin miso = sOut[7]; sOut = {sOut[6:0], 1'b0}; end
      else begin sOut = {sOut[6:0], 1'b0}; miso = sOut[7]; end
    end
    prevSck = sck;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); regAddr = a; #1 v = regRdata;
  endtask

  task automatic cfg(input logic f, input logic [2:0] idx, input logic pol,
                     input logic pha, input logic en);
    tbCpol = pol; tbCpha = pha;
    wr(3'd1, {1'b0, pol, pha, idx, en, 1'b0});
    wr(3'd5, {1'b0, f, 6'b0});
  endtask

  task automatic setSlave(input logic [7:0] b);
    sOut = b;
    if (!tbCpha) miso = b[7];
  endtask

  task automatic startByte(input logic ch, input logic rdc, input logic [7:0] tx);
    if (!rdc) wr(3'd0, tx);
    wr(3'd2, rdc ? 8'h04 : 8'h00);
    wr(3'd3, ch ? 8'h08 : 8'h10);
  endtask

  task automatic waitByte();
    logic [7:0] v;
    for (int k = 0; k < 20000; k++) begin
      rd(3'd4, v);
      if (v[4]) break;
    end
  endtask

  task automatic finishTx();
    wr(3'd4, 8'h10);
    wr(3'd3, 8'h20);
    wr(3'd3, 8'h02);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int per, first, t, gapCnt, dv;
    logic pr;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 csN", csN, 2'b11);
    chk("R1 sck", sck, 0);
    chk("R1 irq", irq, 0);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R1 reg", v, 0);
    end
    // R2 register fields
    wr(3'd1, 8'hFF); rd(3'd1, v); chk("R2 ctrl1", v, 8'h7E);
    wr(3'd2, 8'hFF); rd(3'd2, v); chk("R2 ctrl2", v, 8'h06);
    wr(3'd5, 8'hFF); rd(3'd5, v); chk("R2 clksel", v, 8'h40);
    wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd5, 8'h00);

    // R3 period sweep over both tables, R4 data in mode 0, R13 irq off
    for (int f = 0; f < 2; f++) begin
      for (int i = 0; i < 8; i++) begin
        cfg(f[0], 3'(i), 1'b0, 1'b0, 1'b0);
        setSlave(8'h00);
        startByte(1'b0, 1'b0, 8'(8'h5A ^ (i * 37) ^ (f * 8'hC3)));
        first = -1; t = 0; per = 0; pr = sck;
        for (int k = 0; k < 5000; k++) begin
          @(negedge clk); t++;
          if (!pr && sck) begin
            if (first < 0) first = t;
            else begin per = t - first; break; end
          end
          pr = sck;
        end
        dv = (i == 7) ? (f ? 1 : 16) : 2 * (i + 1);
        chk("R3 sck period", per, 2 * dv * (f ? 1 : 3));
        waitByte();
        chk("R4 mosi byte", slvRx, 8'(8'h5A ^ (i * 37) ^ (f * 8'hC3)));
        chk("R13 irq gated off", irq, 0);
        finishTx();
      end
    end

    // R4 R5 R6 in all four modes
    for (int m = 0; m < 4; m++) begin
      cfg(1'b1, 3'd0, m[1], m[0], 1'b0);
      setSlave(8'h3C ^ 8'(m));
      startByte(m[0], 1'b0, 8'hA7 ^ 8'(m * 16));
      waitByte();
      chk("R4 mode write", slvRx, 8'hA7 ^ 8'(m * 16));
      rd(3'd0, v);
      chk("R6 data kept", v, 8'hA7 ^ 8'(m * 16));
      wr(3'd4, 8'h10);
      setSlave(8'hC9 ^ 8'(m * 5));
      startByte(m[0], 1'b1, 8'h00);
      waitByte();
      rd(3'd0, v);
      chk("R5 read data", v, 8'hC9 ^ 8'(m * 5));
      chk("R5 mosi low", slvRx, 0);
      finishTx();
    end

    // R8 byte-done set and clear collide; R13 irq timing
    cfg(1'b1, 3'd7, 1'b0, 1'b0, 1'b1);
    setSlave(8'h00);
    wr(3'd2, 8'h00);
    wr(3'd3, 8'h10);
    repeat (15) @(negedge clk);
    regAddr = 3'd4; #1;
    chk("R8 not yet done", regRdata[4], 0);
    regWe = 1'b1; regWdata = 8'h10;
    @(negedge clk); regWe = 1'b0; #1;
    chk("R8 set wins", regRdata[4], 1);
    chk("R13 irq delayed", irq, 0);
    @(negedge clk);
    chk("R13 irq rises", irq, 1);
    wr(3'd4, 8'h10);
    rd(3'd4, v);
    chk("R8 cleared", v[4], 0);
    chk("R7 cs held", csN, 2'b10);

    // R9 end and transfer-end flag
    wr(3'd3, 8'h20);
    chk("R9 cs released", csN, 2'b11);
    rd(3'd3, v);
    chk("R9 xfer end", v[1], 1);
    chk("R10 busy clear", v[0], 0);
    wr(3'd3, 8'h02);
    rd(3'd3, v);
    chk("R9 xfer end clear", v[1], 0);
    wr(3'd1, 8'h00);

    // R10 R11 commands ignored mid byte (slow source, longest divisor)
    cfg(1'b0, 3'd7, 1'b0, 1'b0, 1'b0);
    startByte(1'b0, 1'b0, 8'h81);
    rd(3'd3, v);
    chk("R10 in progress", v[2], 1);
    chk("R10 busy", v[0], 1);
    wr(3'd3, 8'h08);
    wr(3'd3, 8'h20);
    chk("R11 cs unchanged", csN, 2'b10);
    waitByte();
    chk("R11 cs still held", csN, 2'b10);
    rd(3'd3, v);
    chk("R11 end ignored", v[1], 0);
    chk("R10 idle between", v[2], 0);
    chk("R10 busy held", v[0], 1);
    wr(3'd4, 8'h10);

    // R12 change of chip select
    cfg(1'b1, 3'd0, 1'b0, 1'b0, 1'b0);
    wr(3'd3, 8'h08);
    gapCnt = (csN == 2'b11) ? 1 : 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (csN == 2'b11) gapCnt++; else break;
    end
    chk("R12 gap length", gapCnt, 4);
    chk("R12 new cs", csN, 2'b01);
    waitByte();
    wr(3'd4, 8'h10);

    // R9 end wins over start in one write
    wr(3'd3, 8'h30);
    chk("R9 end wins cs", csN, 2'b11);
    repeat (20) @(negedge clk);
    rd(3'd3, v);
    chk("R9 end wins flag", v[1], 1);
    chk("R9 no byte", v[2], 0);
    rd(3'd4, v);
    chk("R9 no byte done", v[4], 0);
    wr(3'd3, 8'h02);

    // R7 both start bits: channel 0 wins
    wr(3'd3, 8'h18);
    chk("R7 priority", csN, 2'b10);
    waitByte();
    finishTx();
    chk("R7 released", csN, 2'b11);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule